// File: doc/BRIEF.md
# Speculation-Aware Coalescing Store Buffer

This block sits between a core's retirement stage and its first-level data array. A retired store whose cache block is still missing is parked in an entry one whole block wide. Later stores to the same block merge into that entry byte by byte. When the block's fill arrives, the entry is written into the data array as a single masked block write. Entries are unordered: they are kept by block, not by program order.

Each store is tagged with the core's speculation state at retirement. Speculative and architectural stores for the same block live in separate entries, so a single abort command can discard every speculative entry in one cycle while the architectural ones survive and drain later. When both kinds exist for one block, the architectural data reaches the array first. Among entries that are ready to go, the oldest allocated goes first, one per cycle. The empty flag is the commit condition for the speculation controller. The full flag holds back retirement.

Top module: `spec_store_buffer`

## Requirements
- R1: An entry's drain presents the block address, a per-byte mask equal to the OR of the masks of all stores merged into it (bit b covers data bits 8b+7..8b), and for each masked byte the value of the latest store that wrote it.
- R2: A store whose block address and speculation class (spec_mode_i at retirement) match a live entry that is not draining in that cycle merges into it, so the block drains only once.
- R3: A speculative store and an architectural store to the same block never share an entry; each drains separately.
- R4: An entry drains only after a fill for its block has been seen: drain_valid_o rises in the cycle after fill_valid_i is sampled for that block, and a store allocated to a block that already has a filled live entry, or whose fill arrives in the same cycle, is ready at once.
- R5: flash_spec_i removes every speculative entry in one clock edge; those entries never drain, and architectural entries are kept and drain later.
- R6: While an architectural entry for a block is live, a speculative entry for the same block does not drain, even if it is older.
- R7: At most one entry drains per cycle, and among ready entries the one allocated earliest drains first, regardless of its slot.
- R8: empty_o is 1 exactly when no live entry of either class remains.
- R9: full_o is 1 exactly when every entry is live; while full, a store that matches no live entry of its class is refused (st_ready_o = 0), and a store that matches one is accepted.
- R10: After reset the buffer is empty: empty_o = 1, full_o = 0, drain_valid_o = 0.
- R11: In a cycle with flash_spec_i = 1, st_ready_o is 0 and no speculative entry drains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| spec_mode_i | input | 1 | 1 when the core is speculating; this is the class given to a store |
| st_valid_i | input | 1 | A retired store is offered |
| st_ready_o | output | 1 | The store is taken at this edge |
| st_addr_i | input | BLK_AW | Block address of the store |
| st_mask_i | input | BLOCK_BYTES | Byte enables of the store |
| st_data_i | input | BLOCK_BYTES*8 | Store data, block aligned |
| fill_valid_i | input | 1 | A block fill has completed |
| fill_addr_i | input | BLK_AW | Block address of the fill |
| flash_spec_i | input | 1 | Discard all speculative entries |
| drain_valid_o | output | 1 | Masked block write to the data array this cycle |
| drain_addr_o | output | BLK_AW | Block address of the drain write |
| drain_mask_o | output | BLOCK_BYTES | Byte enables of the drain write |
| drain_data_o | output | BLOCK_BYTES*8 | Data of the drain write |
| empty_o | output | 1 | No live entry |
| full_o | output | 1 | All entries live |

## Verification
The bench builds the buffer with its default shape: eight entries, 64-byte blocks and a 26-bit block address. It then draws random addresses from a pool of only six blocks. With two classes per block this gives twelve possible entries for eight slots, so full stalls, merging while full and slot reuse after a drain all occur often. Same-block pairs of both classes also arise often, which exercises the architectural-first rule under random fills and aborts. Eight slots keep the age relation at 56 bits. That is small enough for directed cases to force a newer entry into a lower slot than an older one, so oldest-first order can be told apart from slot order.

// File: rtl/sb_pkg.sv
package sb_pkg;

    localparam int unsigned SB_ENTRIES_DEF     = 8;
    localparam int unsigned SB_BLOCK_BYTES_DEF = 64;
    localparam int unsigned SB_BLK_AW_DEF      = 26;

    typedef enum logic {
        SB_ARCH = 1'b0,
        SB_SPEC = 1'b1
    } sb_class_e;

    typedef struct packed {
        logic      valid;
        sb_class_e cls;
        logic      filled;
    } sb_meta_t;

    function automatic sb_class_e class_of(input logic spec);
        return spec ? SB_SPEC : SB_ARCH;
    endfunction

    // Ready to leave: live, filled, and not held back by an abort in
    // progress or by an architectural twin for the same block.
    function automatic logic may_drain(input sb_meta_t m, input logic flash,
                                       input logic arch_twin);
        return m.valid && m.filled &&
               !((m.cls == SB_SPEC) && (flash || arch_twin));
    endfunction

endpackage

// File: rtl/sb_entry.sv
module sb_entry
    import sb_pkg::*;
#(
    parameter int unsigned BLOCK_BYTES = SB_BLOCK_BYTES_DEF,
    parameter int unsigned BLK_AW      = SB_BLK_AW_DEF,
    localparam int unsigned DW         = BLOCK_BYTES * 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   alloc_i,
    input  logic                   merge_i,
    input  logic                   drain_i,
    input  logic                   flash_i,
    input  logic                   alloc_filled_i,
    input  sb_class_e              st_cls_i,
    input  logic [BLK_AW-1:0]      st_addr_i,
    input  logic [BLOCK_BYTES-1:0] st_mask_i,
    input  logic [DW-1:0]          st_data_i,
    input  logic                   fill_valid_i,
    input  logic [BLK_AW-1:0]      fill_addr_i,
    output sb_meta_t               meta_o,
    output logic [BLK_AW-1:0]      addr_o,
    output logic [BLOCK_BYTES-1:0] mask_o,
    output logic [DW-1:0]          data_o
);

    sb_meta_t               meta_q;
    logic [BLK_AW-1:0]      addr_q;
    logic [BLOCK_BYTES-1:0] mask_q;
    logic [DW-1:0]          data_q;
    logic                   fill_hit;

    assign fill_hit = fill_valid_i && (fill_addr_i == addr_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
        end else if (drain_i) begin
            meta_q.valid <= 1'b0;
        end else if (flash_i && meta_q.cls == SB_SPEC) begin
            meta_q.valid <= 1'b0;
        end else if (alloc_i) begin
            meta_q.valid  <= 1'b1;
            meta_q.cls    <= st_cls_i;
            meta_q.filled <= alloc_filled_i;
        end else if (meta_q.valid && fill_hit) begin
            meta_q.filled <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            mask_q <= '0;
            data_q <= '0;
        end else if (alloc_i) begin
            addr_q <= st_addr_i;
            mask_q <= st_mask_i;
            for (int b = 0; b < BLOCK_BYTES; b++) begin
                data_q[b*8 +: 8] <= st_mask_i[b] ? st_data_i[b*8 +: 8] : 8'h00;
            end
        end else if (merge_i) begin
            mask_q <= mask_q | st_mask_i;
            for (int b = 0; b < BLOCK_BYTES; b++) begin
                if (st_mask_i[b]) begin
                    data_q[b*8 +: 8] <= st_data_i[b*8 +: 8];
                end
            end
        end
    end

    assign meta_o = meta_q;
    assign addr_o = addr_q;
    assign mask_o = mask_q;
    assign data_o = data_q;

    // R2: allocation only lands in a free slot, merging only in a live one
    assert_alloc_free_R2: assert property (@(posedge clk) disable iff (rst)
        alloc_i |-> !meta_q.valid);
    assert_merge_live_R2: assert property (@(posedge clk) disable iff (rst)
        merge_i |-> meta_q.valid);
    // R5: a speculative entry is gone right after an abort
    assert_flash_drops_R5: assert property (@(posedge clk) disable iff (rst)
        (flash_i && meta_q.valid && meta_q.cls == SB_SPEC) |=> !meta_q.valid);
    // R4: nothing leaves before its fill
    assert_wait_fill_R4: assert property (@(posedge clk) disable iff (rst)
        drain_i |-> (meta_q.valid && meta_q.filled));

endmodule

// File: rtl/sb_age_matrix.sv
module sb_age_matrix #(
    parameter int unsigned N = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [N-1:0]        alloc_oh_i,
    output logic [N-1:0][N-1:0] older_o
);

    // older_q[i][j] = 1 : slot i was allocated before slot j
    logic [N-1:0][N-1:0] older_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            older_q <= '0;
        end else begin
            for (int i = 0; i < N; i++) begin
                for (int j = 0; j < N; j++) begin
                    if (alloc_oh_i[i]) begin
                        older_q[i][j] <= 1'b0;
                    end else if (alloc_oh_i[j] && i != j) begin
                        older_q[i][j] <= 1'b1;
                    end
                end
            end
        end
    end

    assign older_o = older_q;

    assert_single_alloc_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(alloc_oh_i));

    for (genvar gi = 0; gi < N; gi++) begin : g_row
        for (genvar gj = gi + 1; gj < N; gj++) begin : g_col
            // R7: age relation never claims both directions
            assert_age_antisym_R7: assert property (@(posedge clk) disable iff (rst)
                !(older_q[gi][gj] && older_q[gj][gi]));
        end
    end

endmodule

// File: rtl/sb_drain_pick.sv
module sb_drain_pick #(
    parameter int unsigned N = 8
) (
    input  logic [N-1:0]        ready_i,
    input  logic [N-1:0][N-1:0] older_i,
    output logic [N-1:0]        grant_o
);

    for (genvar gi = 0; gi < N; gi++) begin : g_pick
        logic [N-1:0] beaten_by;
        always_comb begin
            for (int j = 0; j < N; j++) begin
                beaten_by[j] = ready_i[j] && older_i[j][gi];
            end
        end
        assign grant_o[gi] = ready_i[gi] && !(|beaten_by);
    end

endmodule

// File: rtl/spec_store_buffer.sv
module spec_store_buffer
    import sb_pkg::*;
#(
    parameter int unsigned ENTRIES     = SB_ENTRIES_DEF,
    parameter int unsigned BLOCK_BYTES = SB_BLOCK_BYTES_DEF,
    parameter int unsigned BLK_AW      = SB_BLK_AW_DEF,
    localparam int unsigned DW         = BLOCK_BYTES * 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   spec_mode_i,
    input  logic                   st_valid_i,
    output logic                   st_ready_o,
    input  logic [BLK_AW-1:0]      st_addr_i,
    input  logic [BLOCK_BYTES-1:0] st_mask_i,
    input  logic [DW-1:0]          st_data_i,
    input  logic                   fill_valid_i,
    input  logic [BLK_AW-1:0]      fill_addr_i,
    input  logic                   flash_spec_i,
    output logic                   drain_valid_o,
    output logic [BLK_AW-1:0]      drain_addr_o,
    output logic [BLOCK_BYTES-1:0] drain_mask_o,
    output logic [DW-1:0]          drain_data_o,
    output logic                   empty_o,
    output logic                   full_o
);

    sb_meta_t               e_meta [ENTRIES];
    logic [BLK_AW-1:0]      e_addr [ENTRIES];
    logic [BLOCK_BYTES-1:0] e_mask [ENTRIES];
    logic [DW-1:0]          e_data [ENTRIES];

    logic [ENTRIES-1:0]              e_live, arch_twin, ready, grant;
    logic [ENTRIES-1:0]              match, alloc_oh, merge_en;
    logic [ENTRIES-1:0][ENTRIES-1:0] older;
    logic                            any_match, accept, alloc_filled;
    sb_class_e                       st_cls;

    assign st_cls = class_of(spec_mode_i);

    // ---------------- per-slot status ----------------
    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            e_live[i]    = e_meta[i].valid;
            arch_twin[i] = 1'b0;
            for (int j = 0; j < ENTRIES; j++) begin
                if (j != i && e_meta[j].valid && e_meta[j].cls == SB_ARCH &&
                    e_addr[j] == e_addr[i]) begin
                    arch_twin[i] = 1'b1;
                end
            end
            ready[i] = may_drain(e_meta[i], flash_spec_i, arch_twin[i]);
        end
    end

    sb_age_matrix #(.N(ENTRIES)) u_age (
        .clk        (clk),
        .rst        (rst),
        .alloc_oh_i (alloc_oh),
        .older_o    (older)
    );

    sb_drain_pick #(.N(ENTRIES)) u_pick (
        .ready_i (ready),
        .older_i (older),
        .grant_o (grant)
    );

    // ---------------- store side ----------------
    always_comb begin
        alloc_filled = fill_valid_i && (fill_addr_i == st_addr_i);
        for (int i = 0; i < ENTRIES; i++) begin
            match[i] = e_meta[i].valid && !grant[i] &&
                       (e_addr[i] == st_addr_i) && (e_meta[i].cls == st_cls);
            if (e_meta[i].valid && e_meta[i].filled && e_addr[i] == st_addr_i) begin
                alloc_filled = 1'b1;
            end
        end
    end

    assign any_match  = |match;
    assign full_o     = &e_live;
    assign empty_o    = ~|e_live;
    assign st_ready_o = !flash_spec_i && (any_match || !full_o);
    assign accept     = st_valid_i && st_ready_o;
    assign merge_en   = accept ? match : '0;
    assign alloc_oh   = (accept && !any_match) ? (~e_live & (e_live + 1'b1)) : '0;

    // ---------------- entries ----------------
    for (genvar gi = 0; gi < ENTRIES; gi++) begin : g_ent
        sb_entry #(
            .BLOCK_BYTES (BLOCK_BYTES),
            .BLK_AW      (BLK_AW)
        ) u_ent (
            .clk            (clk),
            .rst            (rst),
            .alloc_i        (alloc_oh[gi]),
            .merge_i        (merge_en[gi]),
            .drain_i        (grant[gi]),
            .flash_i        (flash_spec_i),
            .alloc_filled_i (alloc_filled),
            .st_cls_i       (st_cls),
            .st_addr_i      (st_addr_i),
            .st_mask_i      (st_mask_i),
            .st_data_i      (st_data_i),
            .fill_valid_i   (fill_valid_i),
            .fill_addr_i    (fill_addr_i),
            .meta_o         (e_meta[gi]),
            .addr_o         (e_addr[gi]),
            .mask_o         (e_mask[gi]),
            .data_o         (e_data[gi])
        );
    end

    // ---------------- drain mux ----------------
    logic drain_spec;
    always_comb begin
        drain_addr_o = '0;
        drain_mask_o = '0;
        drain_data_o = '0;
        drain_spec   = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (grant[i]) begin
                drain_addr_o = drain_addr_o | e_addr[i];
                drain_mask_o = drain_mask_o | e_mask[i];
                drain_data_o = drain_data_o | e_data[i];
                drain_spec   = drain_spec | (e_meta[i].cls == SB_SPEC);
            end
        end
    end
    assign drain_valid_o = |grant;

    // ---------------- checks ----------------
    logic arch_at_drain, dup_class;
    always_comb begin
        arch_at_drain = 1'b0;
        dup_class     = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (e_meta[i].valid && e_meta[i].cls == SB_ARCH && e_addr[i] == drain_addr_o) begin
                arch_at_drain = 1'b1;
            end
            for (int j = i + 1; j < ENTRIES; j++) begin
                if (e_meta[i].valid && e_meta[j].valid && e_addr[i] == e_addr[j] &&
                    e_meta[i].cls == e_meta[j].cls) begin
                    dup_class = 1'b1;
                end
            end
        end
    end

    assert_one_drain_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));
    assert_arch_first_R6: assert property (@(posedge clk) disable iff (rst)
        (drain_valid_o && drain_spec) |-> !arch_at_drain);
    assert_one_entry_per_class_R2: assert property (@(posedge clk) disable iff (rst)
        !dup_class);
    assert_no_spec_drain_in_flash_R11: assert property (@(posedge clk) disable iff (rst)
        flash_spec_i |-> !(drain_valid_o && drain_spec));
    assert_flash_stalls_R11: assert property (@(posedge clk) disable iff (rst)
        flash_spec_i |-> !st_ready_o);
    assert_full_stall_R9: assert property (@(posedge clk) disable iff (rst)
        (full_o && st_valid_i && !any_match) |-> !st_ready_o);
    assert_empty_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        empty_o |-> !drain_valid_o);
    assert_accept_occupies_R8: assert property (@(posedge clk) disable iff (rst)
        accept |=> !empty_o);

endmodule

// File: tb/tb_spec_store_buffer.sv
module tb_spec_store_buffer;

    localparam int N  = 8;
    localparam int BB = 64;
    localparam int AW = 26;
    localparam int DW = BB * 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          spec_mode, st_valid, fill_valid, flash;
    logic [AW-1:0] st_addr, fill_addr;
    logic [BB-1:0] st_mask;
    logic [DW-1:0] st_data;
    logic          st_ready, drain_valid, empty, full;
    logic [AW-1:0] drain_addr;
    logic [BB-1:0] drain_mask;
    logic [DW-1:0] drain_data;

    always #10 clk = ~clk;

    spec_store_buffer #(.ENTRIES(N), .BLOCK_BYTES(BB), .BLK_AW(AW)) dut (
        .clk(clk), .rst(rst), .spec_mode_i(spec_mode),
        .st_valid_i(st_valid), .st_ready_o(st_ready), .st_addr_i(st_addr),
        .st_mask_i(st_mask), .st_data_i(st_data),
        .fill_valid_i(fill_valid), .fill_addr_i(fill_addr), .flash_spec_i(flash),
        .drain_valid_o(drain_valid), .drain_addr_o(drain_addr),
        .drain_mask_o(drain_mask), .drain_data_o(drain_data),
        .empty_o(empty), .full_o(full)
    );

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    // reference state
    logic          m_v [N];
    logic          m_s [N];
    logic          m_f [N];
    logic [AW-1:0] m_a [N];
    logic [BB-1:0] m_m [N];
    logic [DW-1:0] m_d [N];
    logic          m_old [N][N];

    int            log_n;
    logic [BB-1:0] log_mask [64];
    logic          s_dv, s_ready, s_full, s_empty;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string tag, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        st_valid = 1'b0; st_addr = '0; st_mask = '0; st_data = '0;
        fill_valid = 1'b0; fill_addr = '0; flash = 1'b0;
    endtask

    // One clock: compare outputs with the reference, then advance it.
    task automatic step();
        int d, mi, fr;
        logic el [N];
        logic blk, win, inh, e_full, e_empty, e_ready;
        #5;
        d = -1; mi = -1; fr = -1;
        for (int i = 0; i < N; i++) begin
            blk = 1'b0;
            for (int j = 0; j < N; j++)
                if (j != i && m_v[j] && !m_s[j] && m_a[j] == m_a[i]) blk = 1'b1;
            el[i] = m_v[i] && m_f[i] && !(m_s[i] && (flash || blk));
        end
        for (int i = 0; i < N; i++) begin
            if (el[i]) begin
                win = 1'b1;
                for (int j = 0; j < N; j++) if (el[j] && m_old[j][i]) win = 1'b0;
                if (win) d = i;
            end
        end
        e_full = 1'b1; e_empty = 1'b1;
        for (int i = 0; i < N; i++) begin
            if (m_v[i]) e_empty = 1'b0; else e_full = 1'b0;
            if (m_v[i] && i != d && m_a[i] == st_addr && m_s[i] == spec_mode) mi = i;
        end
        e_ready = !flash && (mi >= 0 || !e_full);

        s_dv = drain_valid; s_ready = st_ready; s_full = full; s_empty = empty;
        chk("R7", "drain_valid", {511'd0, drain_valid}, {511'd0, (d >= 0)});
        if (d >= 0) begin
            chk("R7", "drain_addr", {{(DW-AW){1'b0}}, drain_addr}, {{(DW-AW){1'b0}}, m_a[d]});
            chk("R1", "drain_mask", {{(DW-BB){1'b0}}, drain_mask}, {{(DW-BB){1'b0}}, m_m[d]});
            chk("R1", "drain_data", drain_data, m_d[d]);
            if (log_n < 64) log_mask[log_n] = drain_mask;
            log_n++;
        end
        chk("R8", "empty", {511'd0, empty}, {511'd0, e_empty});
        chk("R9", "full", {511'd0, full}, {511'd0, e_full});
        chk("R9", "st_ready", {511'd0, st_ready}, {511'd0, e_ready});

        inh = fill_valid && fill_addr == st_addr;
        for (int i = 0; i < N; i++) begin
            if (m_v[i] && m_f[i] && m_a[i] == st_addr) inh = 1'b1;
            if (!m_v[i] && fr < 0) fr = i;
        end
        if (d >= 0) m_v[d] = 1'b0;
        if (flash) for (int i = 0; i < N; i++) if (m_s[i]) m_v[i] = 1'b0;
        if (fill_valid)
            for (int i = 0; i < N; i++) if (m_v[i] && m_a[i] == fill_addr) m_f[i] = 1'b1;
        if (st_valid && e_ready) begin
            if (mi >= 0) begin
                m_m[mi] = m_m[mi] | st_mask;
                for (int b = 0; b < BB; b++)
                    if (st_mask[b]) m_d[mi][b*8 +: 8] = st_data[b*8 +: 8];
            end else begin
                m_v[fr] = 1'b1; m_s[fr] = spec_mode; m_f[fr] = inh;
                m_a[fr] = st_addr; m_m[fr] = st_mask;
                for (int b = 0; b < BB; b++)
                    m_d[fr][b*8 +: 8] = st_mask[b] ? st_data[b*8 +: 8] : 8'h00;
                for (int j = 0; j < N; j++) begin
                    m_old[fr][j] = 1'b0;
                    if (j != fr) m_old[j][fr] = 1'b1;
                end
            end
        end
        @(posedge clk);
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic store(input int a, input logic [BB-1:0] m, input logic sp);
        st_valid = 1'b1; st_addr = AW'(a); st_mask = m; spec_mode = sp;
        for (int w = 0; w < DW / 32; w++) st_data[w*32 +: 32] = $urandom;
        step();
    endtask

    task automatic fill(input int a);
        fill_valid = 1'b1; fill_addr = AW'(a);
        step();
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) step();
    endtask

    initial begin
        void'($urandom(32'd20240611));
        spec_mode = 1'b0;
        idle_inputs();
        for (int i = 0; i < N; i++) begin
            m_v[i] = 0; m_s[i] = 0; m_f[i] = 0; m_a[i] = '0; m_m[i] = '0; m_d[i] = '0;
            for (int j = 0; j < N; j++) m_old[i][j] = 1'b0;
        end
        log_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R10: reset state
        chk("R10", "empty after reset", {511'd0, empty}, {511'd0, 1'b1});
        chk("R10", "full after reset", {511'd0, full}, {511'd0, 1'b0});
        chk("R10", "drain after reset", {511'd0, drain_valid}, {511'd0, 1'b0});
        idle(2);

        // R1 R2 R4: two architectural stores merge, drain one cycle after fill
        log_n = 0;
        store(100, 64'h0000_0000_0000_000F, 1'b0);
        store(100, 64'h0000_0000_0000_00F0, 1'b0);
        idle(2);
        fill(100);
        chk("R4", "no drain in fill cycle", {511'd0, s_dv}, {511'd0, 1'b0});
        step();
        chk("R4", "drain cycle after fill", {511'd0, s_dv}, {511'd0, 1'b1});
        idle(2);
        chk("R2", "merged block drained once", DW'(log_n), DW'(1));
        chk("R1", "merged byte mask", {{(DW-BB){1'b0}}, log_mask[0]}, DW'(64'hFF));

        // R3: speculative and architectural stores to one block stay apart
        log_n = 0;
        store(110, 64'h1, 1'b0);
        store(110, 64'h2, 1'b1);
        fill(110);
        idle(4);
        chk("R3", "two drains for split classes", DW'(log_n), DW'(2));

        // R6: older speculative entry waits for the architectural one
        log_n = 0;
        store(120, 64'h1, 1'b1);
        store(120, 64'h2, 1'b0);
        fill(120);
        idle(4);
        chk("R6", "drain count", DW'(log_n), DW'(2));
        chk("R6", "architectural first", {{(DW-BB){1'b0}}, log_mask[0]}, DW'(64'h2));
        chk("R6", "speculative second", {{(DW-BB){1'b0}}, log_mask[1]}, DW'(64'h1));

        // R5: abort keeps only architectural entries
        log_n = 0;
        store(300, 64'h1, 1'b1);
        store(301, 64'h40, 1'b0);
        store(301, 64'h80, 1'b1);
        flash = 1'b1;
        step();
        fill(300);
        fill(301);
        idle(4);
        chk("R5", "only architectural entry drains", DW'(log_n), DW'(1));
        chk("R5", "surviving mask", {{(DW-BB){1'b0}}, log_mask[0]}, DW'(64'h40));
        chk("R5", "empty afterwards", {511'd0, s_empty}, {511'd0, 1'b1});

        // R7: a newer entry in a lower slot waits for an older one
        log_n = 0;
        store(420, 64'h10, 1'b0);
        store(421, 64'h01, 1'b1);
        store(421, 64'h02, 1'b0);
        fill(420);
        idle(1);
        store(422, 64'h04, 1'b0);
        fill(421);
        fill(422);
        idle(4);
        chk("R7", "drain count", DW'(log_n), DW'(4));
        chk("R7", "third drain is oldest ready", {{(DW-BB){1'b0}}, log_mask[2]}, DW'(64'h01));
        chk("R7", "fourth drain is newest", {{(DW-BB){1'b0}}, log_mask[3]}, DW'(64'h04));

        // R9 R11: full, stall, merge while full, abort stall
        for (int k = 0; k < 4; k++) begin
            store(200 + k, 64'h1, 1'b0);
            store(200 + k, 64'h2, 1'b1);
        end
        chk("R9", "full with eight entries", {511'd0, full}, {511'd0, 1'b1});
        store(250, 64'h1, 1'b0);
        chk("R9", "new block refused when full", {511'd0, s_ready}, {511'd0, 1'b0});
        store(201, 64'h8, 1'b0);
        chk("R9", "matching store taken when full", {511'd0, s_ready}, {511'd0, 1'b1});
        flash = 1'b1;
        store(201, 64'h8, 1'b0);
        chk("R11", "refused during abort", {511'd0, s_ready}, {511'd0, 1'b0});
        for (int k = 0; k < 4; k++) fill(200 + k);
        idle(3);
        chk("R8", "empty after all drained", {511'd0, s_empty}, {511'd0, 1'b1});

        // random traffic over a small block pool
        for (int t = 0; t < 4000; t++) begin
            if ($urandom_range(99) < 60) begin
                st_valid = 1'b1;
                st_addr  = AW'(500 + $urandom_range(5));
                st_mask  = {$urandom, $urandom};
                for (int w = 0; w < DW / 32; w++) st_data[w*32 +: 32] = $urandom;
            end
            spec_mode = ($urandom_range(99) < 50);
            if ($urandom_range(99) < 18) begin
                fill_valid = 1'b1;
                fill_addr  = AW'(500 + $urandom_range(5));
            end
            if ($urandom_range(99) < 3) flash = 1'b1;
            step();
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule